// File: doc/BRIEF.md
# RTC Status Flag Register

This block holds the status flags of a real-time clock and returns them as one byte over a simple register bus. Five flags live here: an alarm flag, a daylight-saving-adjusted flag, a total-power-fail flag, a low-main-supply flag and an oscillator-fail flag. Each flag has its own rules for being set and cleared. Some flags are sticky and cleared only by a write of zero. One follows a supply comparator directly. One is raised only after both supplies were lost, and the first timekeeping write lowers it.

The timekeeping counters, the alarm comparator and the daylight-saving date matcher sit outside this block. They report to it through single-cycle strobes. The block also watches a 1 Hz tick and raises the oscillator-fail flag when the tick stops arriving. Software reads the status byte with a read strobe. The byte appears on `rd_data` one cycle later, and `rd_data` is zero in every other cycle.

Top module: `rtc_status_reg`

## Requirements
- R1: A read strobe with `bus_addr` equal to `STAT_ADDR` returns the flags on `rd_data` in the next cycle, in this layout: bit 0 alarm, bit 1 DST-adjusted, bit 2 low-main, bit 3 oscillator-fail, bit 4 power-fail, bits 7:5 zero. A read of any other address returns zero in that cycle. In every cycle that does not follow a read strobe, `rd_data` is zero.
- R2: An `alarm_match` pulse sets the alarm flag. A status write with data bit 0 equal to 0 clears the flag. A status write with data bit 0 equal to 1 leaves the flag unchanged.
- R3: An `alarm_match` in the same cycle as a status read, or in the same cycle as a clearing write, leaves the alarm flag set afterwards.
- R4: With `arst_en` at 1, a status read that returns the alarm flag as 1 clears the flag when the read ends. With `arst_en` at 0, a read leaves the flag unchanged.
- R5: With `dst_en` at 1, a `dst_fwd` pulse sets the DST-adjusted flag and a `dst_rev` pulse clears it. When both pulses arrive in the same cycle, the reverse pulse wins. Without either pulse the flag holds.
- R6: While `dst_en` is 0, the DST-adjusted flag is forced to 0, and both events and writes are ignored. With `dst_en` at 1, a status write loads data bit 1 into the flag.
- R7: After reset, the power-fail flag equals `both_lost` as sampled in the last reset cycle. Changes of `on_main`, `both_lost` pulses after reset, and status writes do not change the flag.
- R8: Any write to an address from 0 to `TK_LAST` clears the power-fail flag. A write to an address above `TK_LAST` leaves the flag unchanged.
- R9: While `on_main` is 1, the low-main flag takes the value of `low_main_cmp` one cycle later. While `on_main` is 0, the flag holds its value.
- R10: The oscillator-fail flag rises once `OSC_LIMIT` clock cycles have passed since the last `osc_tick`. It falls in the cycle after an `osc_tick`.
- R11: Reset clears the alarm, DST-adjusted, low-main and oscillator-fail flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after a read strobe, otherwise zero |
| alarm_match | input | 1 | Alarm comparator match pulse |
| arst_en | input | 1 | Alarm auto-clear on read enable |
| dst_fwd | input | 1 | Daylight-saving forward event pulse |
| dst_rev | input | 1 | Daylight-saving reverse event pulse |
| dst_en | input | 1 | Daylight-saving enable level |
| on_main | input | 1 | 1 while running from the main supply |
| both_lost | input | 1 | Total-power-loss indication, sampled during reset |
| low_main_cmp | input | 1 | Main-supply low comparator output |
| osc_tick | input | 1 | 1 Hz tick pulse in the clock domain |

## Verification
The assertions check every cycle that no write can set the alarm flag, that a match always leaves the alarm flag set, and that auto-clear fires after a read that returned 1. They also check that a disabled DST feature forces its flag low, that the power-fail flag changes only on a timekeeping write, that the low-main flag tracks its comparator while on main supply, and that a tick clears the oscillator flag. Some behaviours only the bench scenarios can show. These are the exact byte layout seen over the bus, the snapshot returned by a read that collides with a new alarm, the sampling of total loss across a reset, and the exact cycle in which the oscillator timeout fires.

// File: rtl/rtcsr_pkg.sv
package rtcsr_pkg;

  localparam int unsigned STAT_W   = 8;
  localparam int unsigned ALM_BIT  = 0;
  localparam int unsigned DST_BIT  = 1;
  localparam int unsigned LOWM_BIT = 2;
  localparam int unsigned OSCF_BIT = 3;
  localparam int unsigned PWRF_BIT = 4;

  typedef struct packed {
    logic pwr_fail;
    logic osc_fail;
    logic low_main;
    logic dst_adj;
    logic alarm;
  } flags_t;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_LOAD = 2'd3
  } flag_act_t;

  // Place each flag at its bit position in the status byte.
  function automatic logic [STAT_W-1:0] pack_status(input flags_t f);
    logic [STAT_W-1:0] v;
    v           = '0;
    v[ALM_BIT]  = f.alarm;
    v[DST_BIT]  = f.dst_adj;
    v[LOWM_BIT] = f.low_main;
    v[OSCF_BIT] = f.osc_fail;
    v[PWRF_BIT] = f.pwr_fail;
    return v;
  endfunction

  // Alarm flag: a new match beats every clearing source.
  function automatic flag_act_t alarm_action(input logic match,
                                             input logic wr_clear,
                                             input logic auto_clear);
    if (match)                        return ACT_SET;
    else if (wr_clear || auto_clear)  return ACT_CLR;
    else                              return ACT_HOLD;
  endfunction

  // DST flag: disable beats reverse, reverse beats forward, forward beats a write.
  function automatic flag_act_t dst_action(input logic enable,
                                           input logic fwd,
                                           input logic rev,
                                           input logic wr);
    if (!enable)   return ACT_CLR;
    else if (rev)  return ACT_CLR;
    else if (fwd)  return ACT_SET;
    else if (wr)   return ACT_LOAD;
    else           return ACT_HOLD;
  endfunction

endpackage

// File: rtl/rtcsr_bus_decode.sv
module rtcsr_bus_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STAT_ADDR = 15,
  parameter int unsigned TK_LAST   = 6
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              stat_wr,
  output logic              stat_rd,
  output logic              tk_wr
);

  localparam logic [ADDR_W-1:0] STAT_A = STAT_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] TK_A   = TK_LAST[ADDR_W-1:0];

  logic addr_is_stat;
  logic addr_in_tk;

  assign addr_is_stat = (bus_addr == STAT_A);
  assign addr_in_tk   = (bus_addr <= TK_A);

  assign stat_wr = bus_wr && addr_is_stat;
  assign stat_rd = bus_rd && addr_is_stat;
  assign tk_wr   = bus_wr && addr_in_tk;

endmodule

// File: rtl/rtcsr_alarm_flag.sv
module rtcsr_alarm_flag
  import rtcsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic alarm_match,
  input  logic arst_en,
  input  logic stat_wr,
  input  logic wr_bit,
  input  logic stat_rd,
  output logic alarm
);

  logic      wr_clear_ev;
  logic      auto_clear_ev;
  flag_act_t act;

  assign wr_clear_ev   = stat_wr && !wr_bit;
  assign auto_clear_ev = arst_en && stat_rd && alarm;
  assign act           = alarm_action(alarm_match, wr_clear_ev, auto_clear_ev);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm <= 1'b0;
    end else begin
      case (act)
        ACT_SET: alarm <= 1'b1;
        ACT_CLR: alarm <= 1'b0;
        default: alarm <= alarm;
      endcase
    end
  end

  // R2
  alm_no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm && !alarm_match) |=> !alarm);

  // R3
  alm_match_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_match |=> alarm);

  // R4
  alm_auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arst_en && stat_rd && alarm && !alarm_match) |=> !alarm);

endmodule

// File: rtl/rtcsr_dst_flag.sv
module rtcsr_dst_flag
  import rtcsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dst_en,
  input  logic dst_fwd,
  input  logic dst_rev,
  input  logic stat_wr,
  input  logic wr_bit,
  output logic dst_adj
);

  flag_act_t act;

  assign act = dst_action(dst_en, dst_fwd, dst_rev, stat_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dst_adj <= 1'b0;
    end else begin
      case (act)
        ACT_SET:  dst_adj <= 1'b1;
        ACT_CLR:  dst_adj <= 1'b0;
        ACT_LOAD: dst_adj <= wr_bit;
        default:  dst_adj <= dst_adj;
      endcase
    end
  end

  // R6
  dst_off_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_en |=> !dst_adj);

  // R5
  dst_rev_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && dst_rev) |=> !dst_adj);

  // R5
  dst_fwd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && dst_fwd && !dst_rev) |=> dst_adj);

endmodule

// File: rtl/rtcsr_supply_flags.sv
module rtcsr_supply_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic both_lost,
  input  logic tk_wr,
  input  logic on_main,
  input  logic low_main_cmp,
  output logic pwr_fail,
  output logic low_main
);

  // Power-fail is loaded from the loss indication during reset and is
  // cleared only by a timekeeping write afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_fail <= both_lost;
    end else if (tk_wr) begin
      pwr_fail <= 1'b0;
    end
  end

  // Low-main follows the comparator only while the main supply is in use.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_main <= 1'b0;
    end else if (on_main) begin
      low_main <= low_main_cmp;
    end
  end

  // R8
  pwr_tk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tk_wr |=> !pwr_fail);

  // R7
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tk_wr |=> $stable(pwr_fail));

  // R9
  lowm_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    on_main |=> (low_main == $past(low_main_cmp)));

  // R9
  lowm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on_main |=> $stable(low_main));

endmodule

// File: rtl/rtcsr_osc_watch.sv
module rtcsr_osc_watch #(
  parameter int unsigned OSC_LIMIT = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  output logic osc_fail
);

  localparam int unsigned CNT_W = $clog2(OSC_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = OSC_LIMIT[CNT_W-1:0];

  logic [CNT_W-1:0] gap_cnt;
  logic             expired;

  // Next value of the gap counter: restart on a tick, saturate at the limit.
  function automatic logic [CNT_W-1:0] gap_next(input logic [CNT_W-1:0] c,
                                                input logic tick);
    if (tick)          return '0;
    else if (c == LIM) return c;
    else               return c + 1'b1;
  endfunction

  assign expired  = (gap_cnt == LIM);
  assign osc_fail = expired;

  always_ff @(posedge clk) begin
    if (!rst_n) gap_cnt <= '0;
    else        gap_cnt <= gap_next(gap_cnt, osc_tick);
  end

  // R10
  osc_tick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick |=> !osc_fail);

  // R10
  osc_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_fail && !osc_tick) |=> osc_fail);

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
  import rtcsr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STAT_ADDR = 15,
  parameter int unsigned TK_LAST   = 6,
  parameter int unsigned OSC_LIMIT = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        rd_data,
  input  logic              alarm_match,
  input  logic              arst_en,
  input  logic              dst_fwd,
  input  logic              dst_rev,
  input  logic              dst_en,
  input  logic              on_main,
  input  logic              both_lost,
  input  logic              low_main_cmp,
  input  logic              osc_tick
);

  logic   stat_wr;
  logic   stat_rd;
  logic   tk_wr;
  flags_t flags;
  logic   unused_wdata;

  // Read-only bits of the write data are ignored.
  assign unused_wdata = ^{bus_wdata[7:2]};

  rtcsr_bus_decode #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .TK_LAST  (TK_LAST)
  ) u_dec (
    .bus_addr(bus_addr),
    .bus_wr  (bus_wr),
    .bus_rd  (bus_rd),
    .stat_wr (stat_wr),
    .stat_rd (stat_rd),
    .tk_wr   (tk_wr)
  );

  rtcsr_alarm_flag u_alarm (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_match(alarm_match),
    .arst_en    (arst_en),
    .stat_wr    (stat_wr),
    .wr_bit     (bus_wdata[ALM_BIT]),
    .stat_rd    (stat_rd),
    .alarm      (flags.alarm)
  );

  rtcsr_dst_flag u_dst (
    .clk    (clk),
    .rst_n  (rst_n),
    .dst_en (dst_en),
    .dst_fwd(dst_fwd),
    .dst_rev(dst_rev),
    .stat_wr(stat_wr),
    .wr_bit (bus_wdata[DST_BIT]),
    .dst_adj(flags.dst_adj)
  );

  rtcsr_supply_flags u_supply (
    .clk         (clk),
    .rst_n       (rst_n),
    .both_lost   (both_lost),
    .tk_wr       (tk_wr),
    .on_main     (on_main),
    .low_main_cmp(low_main_cmp),
    .pwr_fail    (flags.pwr_fail),
    .low_main    (flags.low_main)
  );

  rtcsr_osc_watch #(
    .OSC_LIMIT(OSC_LIMIT)
  ) u_osc (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_tick(osc_tick),
    .osc_fail(flags.osc_fail)
  );

  // Status snapshot is taken at the read edge; zero otherwise.
  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (stat_rd) rd_data <= pack_status(flags);
    else              rd_data <= '0;
  end

  // R1
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (rd_data == 8'h00));

  // R1
  rd_pad_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

endmodule

// File: tb/tb_rtc_status_reg.sv
module tb_rtc_status_reg;

  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned STAT_ADDR = 15;
  localparam int unsigned TK_LAST   = 6;
  localparam int unsigned OSC_LIMIT = 40;
  localparam logic [7:0]  SA        = 8'd15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd = 1'b0;
  logic [7:0] rd_data;
  logic       alarm_match = 1'b0;
  logic       arst_en = 1'b0;
  logic       dst_fwd = 1'b0;
  logic       dst_rev = 1'b0;
  logic       dst_en = 1'b0;
  logic       on_main = 1'b1;
  logic       both_lost = 1'b0;
  logic       low_main_cmp = 1'b0;
  logic       osc_tick = 1'b0;
  logic       tick_en = 1'b1;

  always #5 clk = ~clk;

  rtc_status_reg #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .TK_LAST(TK_LAST), .OSC_LIMIT(OSC_LIMIT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data),
    .alarm_match(alarm_match), .arst_en(arst_en), .dst_fwd(dst_fwd),
    .dst_rev(dst_rev), .dst_en(dst_en), .on_main(on_main),
    .both_lost(both_lost), .low_main_cmp(low_main_cmp), .osc_tick(osc_tick)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    n_chk = 0;
  int    n_fail = 0;
  logic  rd_q = 1'b0;

  // Expected status byte: bit0 alarm, bit1 dst, bit2 low-main, bit3 osc, bit4 pwr.
  function automatic logic [7:0] st(input bit a, input bit d, input bit l,
                                    input bit o, input bit p);
    return {3'b000, p, o, l, d, a};
  endfunction

  task automatic cyc(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver: queue the expected byte, then issue the read.
  task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    sbq.push_back('{exp: exp, tag: tag});
    bus_addr = addr;
    bus_rd   = 1'b1;
    cyc();
    bus_rd   = 1'b0;
    cyc();
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] data);
    bus_addr  = addr;
    bus_wdata = data;
    bus_wr    = 1'b1;
    cyc();
    bus_wr    = 1'b0;
  endtask

  task automatic do_reset(input logic lost);
    rst_n     = 1'b0;
    both_lost = lost;
    cyc(3);
    rst_n     = 1'b1;
    both_lost = 1'b0;
    cyc();
  endtask

  always @(posedge clk) rd_q <= bus_rd;

  // Monitor: compare each read result against the queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_q) begin
        n_chk++;
        if (sbq.size() == 0) begin
          n_fail++;
          $display("FAIL R1 unexpected read result actual=%02h expected=none", rd_data);
        end else begin
          item_t it;
          it = sbq.pop_front();
          if (rd_data !== it.exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", it.tag, rd_data, it.exp);
          end
        end
      end else if (rd_data !== 8'h00) begin
        n_chk++;
        n_fail++;
        $display("FAIL R1 idle read data actual=%02h expected=00", rd_data);
      end
    end
  end

  // Background 1 Hz tick stand-in.
  initial begin
    forever begin
      cyc(16);
      if (tick_en) begin
        osc_tick = 1'b1;
        cyc();
        osc_tick = 1'b0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R7 R11: total loss seen during reset
    do_reset(1'b1);
    rd(SA, st(0,0,0,0,1), "R11_R7 reset state");
    rd(8'd2, 8'h00, "R1 non-status address");

    // R7: single-supply changes and late loss pulses ignored
    on_main = 1'b0; cyc(3); on_main = 1'b1; cyc(2);
    both_lost = 1'b1; cyc(); both_lost = 1'b0;
    rd(SA, st(0,0,0,0,1), "R7 single supply loss");

    // R2 R6 R7: write of all ones sets nothing
    wr(SA, 8'hFF); cyc();
    rd(SA, st(0,0,0,0,1), "R2_R6_R7 write ones");

    // R8: write above timekeeping range keeps, inside clears
    wr(8'd7, 8'h12); cyc();
    rd(SA, st(0,0,0,0,1), "R8 write outside range");
    wr(8'd3, 8'h00); cyc();
    rd(SA, st(0,0,0,0,0), "R8 timekeeping write");

    // R2: alarm set and write rules
    alarm_match = 1'b1; cyc(); alarm_match = 1'b0;
    rd(SA, st(1,0,0,0,0), "R2 alarm set");
    rd(SA, st(1,0,0,0,0), "R4 no auto clear when off");
    wr(SA, 8'h01); cyc();
    rd(SA, st(1,0,0,0,0), "R2 write one keeps");
    wr(SA, 8'h00); cyc();
    rd(SA, st(0,0,0,0,0), "R2 write zero clears");

    // R3: match during a read with auto-clear on
    arst_en = 1'b1;
    alarm_match = 1'b1;
    rd(SA, st(0,0,0,0,0), "R3 snapshot before match");
    alarm_match = 1'b0;
    rd(SA, st(1,0,0,0,0), "R3 alarm kept after read");
    rd(SA, st(0,0,0,0,0), "R4 auto clear after read");
    arst_en = 1'b0;

    // R3: match beats a clearing write
    alarm_match = 1'b1;
    wr(SA, 8'h00);
    alarm_match = 1'b0; cyc();
    rd(SA, st(1,0,0,0,0), "R3 match beats write");
    wr(SA, 8'h00); cyc();

    // R5: DST events
    dst_en = 1'b1; cyc();
    dst_fwd = 1'b1; cyc(); dst_fwd = 1'b0;
    rd(SA, st(0,1,0,0,0), "R5 forward sets");
    rd(SA, st(0,1,0,0,0), "R5 holds");
    dst_rev = 1'b1; cyc(); dst_rev = 1'b0;
    rd(SA, st(0,0,0,0,0), "R5 reverse clears");
    dst_fwd = 1'b1; cyc(); dst_fwd = 1'b0;
    dst_fwd = 1'b1; dst_rev = 1'b1; cyc(); dst_fwd = 1'b0; dst_rev = 1'b0;
    rd(SA, st(0,0,0,0,0), "R5 reverse wins");

    // R6: software load and disable
    wr(SA, 8'h02); cyc();
    rd(SA, st(0,1,0,0,0), "R6 software set");
    wr(SA, 8'h00); cyc();
    rd(SA, st(0,0,0,0,0), "R6 software clear");
    wr(SA, 8'h02); cyc();
    dst_en = 1'b0; cyc();
    rd(SA, st(0,0,0,0,0), "R6 disable clears");
    dst_fwd = 1'b1; cyc(); dst_fwd = 1'b0;
    wr(SA, 8'h02); cyc();
    rd(SA, st(0,0,0,0,0), "R6 disabled ignores");

    // R9: low main supply
    low_main_cmp = 1'b1; cyc();
    rd(SA, st(0,0,1,0,0), "R9 follows comparator");
    on_main = 1'b0; low_main_cmp = 1'b0; cyc(2);
    rd(SA, st(0,0,1,0,0), "R9 holds on battery");
    on_main = 1'b1; cyc();
    rd(SA, st(0,0,0,0,0), "R9 clears on main");

    // R10: oscillator stop timing
    tick_en = 1'b0; cyc(20);
    osc_tick = 1'b1; cyc(); osc_tick = 1'b0;
    cyc(OSC_LIMIT - 1);
    rd(SA, st(0,0,0,0,0), "R10 one cycle before limit");
    rd(SA, st(0,0,0,1,0), "R10 oscillator fail");
    osc_tick = 1'b1; cyc(); osc_tick = 1'b0;
    rd(SA, st(0,0,0,0,0), "R10 tick clears");
    tick_en = 1'b1;

    // R11 R7: reset without total loss clears everything
    alarm_match = 1'b1; cyc(); alarm_match = 1'b0;
    dst_en = 1'b1; dst_fwd = 1'b1; cyc(); dst_fwd = 1'b0;
    do_reset(1'b0);
    dst_en = 1'b0;
    rd(SA, st(0,0,0,0,0), "R11_R7 reset clears flags");

    cyc(4);
    if (sbq.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 missing reads actual=%0d expected=0", sbq.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule